// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output stage of a sum-of-products logic device. It receives the product terms that belong to it from the AND array, ORs them into a single sum, and applies a programmable inversion. Configuration bits then route that value to a pad, in one of four ways. It can pass through a D flip-flop to form a registered output, go straight out as a combinational output, go out as a combinational I/O, or be discarded so that the pad serves as a dedicated input. The same bits choose the signal the cell returns to the array on its feedback line: the register state, the pad itself, or the pin of the neighbouring cell.

Two global configuration bits are shared by every cell on the device, and two local bits belong to each cell. The second global bit and the first local bit together pick the mode. The local inversion bit sets polarity. The feedback multiplexer of an ordinary cell follows the second global bit. The cells at either end of the row (index 0 and index `NUM_CELLS-1`) follow the first global bit there instead. A cell set as a dedicated input has no feedback path of its own into the array, so its pin value reaches the array through the feedback line of its neighbour. The flip-flop takes its clock and its active-low output enable from pins shared by all cells. It clears on power-up reset, and a preload strobe can force it to a chosen value for test. There is no data stream here, so all pins are plain level signals with no handshake.

Top module: `pal_out_cell`

## Requirements
- R1: The cell output value is the OR of all `sop_terms` bits XORed with `cfg_loc_inv` (1 inverts). In combinational output mode (`cfg_glob1`=0, `cfg_loc_mode`=0) and combinational I/O mode (`cfg_glob1`=1, `cfg_loc_mode`=1), `pad_out` equals that value in the same cycle.
- R2: On every rising `clk` edge with `preload_en`=0, the register captures the cell output value. In registered mode (`cfg_glob1`=1, `cfg_loc_mode`=0), `pad_out` shows the register state.
- R3: In registered mode, `pad_oe` equals the inverse of `shared_oe_n`.
- R4: In combinational I/O mode, `pad_oe` is 1. In a non-edge cell, `fb_o` equals `pad_in`.
- R5: In combinational output mode, `pad_oe` is 1. In a non-edge cell, `fb_o` equals `adj_pin`.
- R6: In dedicated input mode (`cfg_glob1`=0, `cfg_loc_mode`=1), `pad_oe` is 0 and `pad_out` is 0. In a non-edge cell, `fb_o` equals `adj_pin`.
- R7: In an edge cell (index 0 or `NUM_CELLS-1`), the feedback source depends on `cfg_glob0` and `cfg_loc_mode`, and `cfg_glob1` has no effect on it. When `cfg_glob0`=1, `fb_o` is the register state if `cfg_loc_mode`=0 and `pad_in` if `cfg_loc_mode`=1. When `cfg_glob0`=0, `fb_o` is `adj_pin`.
- R8: While `rst_n` is low, the register holds 0, so in registered mode both `pad_out` and the register feedback read 0.
- R9: A rising `clk` edge with `preload_en`=1 loads `preload_val` into the register, whatever the array terms are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| cfg_glob0 | input | 1 | Global bit steering edge-cell feedback |
| cfg_glob1 | input | 1 | Global bit: registered/I-O family versus plain combinational family |
| cfg_loc_mode | input | 1 | Local mode bit |
| cfg_loc_inv | input | 1 | Local polarity bit, 1 inverts |
| shared_oe_n | input | 1 | Shared active-low output enable for registered cells |
| sop_terms | input | N_TERMS | Product terms from the AND array |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value to preload |
| pad_in | input | 1 | Level seen on the pad |
| adj_pin | input | 1 | Pad level of the neighbouring cell |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback line into the array |

## Verification
The bench sweeps every combination of the four configuration bits, all term patterns of a four-term cell, the shared enable, pad, neighbour and preload inputs. It drives an ordinary cell and an edge cell side by side. A cell that confused the two global bits would be caught in the edge cell: its feedback would follow `cfg_glob1` when `cfg_glob0` and `cfg_glob1` differ. An inverted enable sense would make a registered pad float when `shared_oe_n` is low. A register that ignored preload, or applied polarity after the flip-flop, would show the wrong state one cycle after the strobe. Reset is asserted both at start-up and after a 1 has been preloaded, which exposes a register that does not clear asynchronously.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;

  // Mode code is {cfg_glob1, cfg_loc_mode}
  typedef enum logic [1:0] {
    MODE_COMB_OUT = 2'b00,
    MODE_DED_IN   = 2'b01,
    MODE_REG_OUT  = 2'b10,
    MODE_COMB_IO  = 2'b11
  } cell_mode_e;

  typedef enum logic [1:0] {
    FB_ADJ = 2'b00,
    FB_REG = 2'b01,
    FB_PAD = 2'b10
  } fb_src_e;

  function automatic cell_mode_e decode_mode(input logic glob1, input logic loc_mode);
    return cell_mode_e'({glob1, loc_mode});
  endfunction

  function automatic fb_src_e decode_fb(input logic gsel, input logic loc_mode);
    if (!gsel)         return FB_ADJ;
    else if (loc_mode) return FB_PAD;
    else               return FB_REG;
  endfunction

endpackage

// File: rtl/pal_sop_or.sv
module pal_sop_or #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] terms_i,
  input  logic               inv_i,
  output logic               val_o
);
  logic [N_TERMS:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_TERMS; g++) begin : g_or
    assign chain[g+1] = chain[g] | terms_i[g];
  end

  assign val_o = chain[N_TERMS] ^ inv_i;
endmodule

// File: rtl/pal_cell_reg.sv
module pal_cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= 1'b0;
    else if (pl_en_i) q_o <= pl_val_i;
    else              q_o <= d_i;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_en_i |=> (q_o == $past(d_i)));

  p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_en_i |=> (q_o == $past(pl_val_i)));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_o == 1'b0));
endmodule

// File: rtl/pal_cell_drive.sv
module pal_cell_drive
  import pal_cell_pkg::*;
(
  input  cell_mode_e mode_i,
  input  logic       comb_i,
  input  logic       q_i,
  input  logic       oe_n_i,
  output logic       pad_out_o,
  output logic       pad_oe_o
);
  always_comb begin
    unique case (mode_i)
      MODE_REG_OUT:  begin pad_out_o = q_i;    pad_oe_o = ~oe_n_i; end
      MODE_COMB_IO:  begin pad_out_o = comb_i; pad_oe_o = 1'b1;    end
      MODE_COMB_OUT: begin pad_out_o = comb_i; pad_oe_o = 1'b1;    end
      default:       begin pad_out_o = 1'b0;   pad_oe_o = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/pal_cell_fb.sv
module pal_cell_fb
  import pal_cell_pkg::*;
#(
  parameter bit IS_EDGE = 1'b0
) (
  input  logic glob0_i,
  input  logic glob1_i,
  input  logic loc_mode_i,
  input  logic q_i,
  input  logic pad_i,
  input  logic adj_i,
  output logic fb_o
);
  logic    gsel;
  fb_src_e src;

  assign gsel = IS_EDGE ? glob0_i : glob1_i;
  assign src  = decode_fb(gsel, loc_mode_i);

  always_comb begin
    unique case (src)
      FB_REG:  fb_o = q_i;
      FB_PAD:  fb_o = pad_i;
      default: fb_o = adj_i;
    endcase
  end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_cell_pkg::*;
#(
  parameter int N_TERMS    = 8,
  parameter int NUM_CELLS  = 8,
  parameter int CELL_INDEX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_glob0,
  input  logic               cfg_glob1,
  input  logic               cfg_loc_mode,
  input  logic               cfg_loc_inv,
  input  logic               shared_oe_n,
  input  logic [N_TERMS-1:0] sop_terms,
  input  logic               preload_en,
  input  logic               preload_val,
  input  logic               pad_in,
  input  logic               adj_pin,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               fb_o
);
  localparam bit IS_EDGE = (CELL_INDEX == 0) || (CELL_INDEX == NUM_CELLS - 1);

  logic       cell_val;
  logic       reg_q;
  cell_mode_e mode;

  assign mode = decode_mode(cfg_glob1, cfg_loc_mode);

  pal_sop_or #(.N_TERMS(N_TERMS)) u_sum (
    .terms_i (sop_terms),
    .inv_i   (cfg_loc_inv),
    .val_o   (cell_val)
  );

  pal_cell_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (cell_val),
    .pl_en_i  (preload_en),
    .pl_val_i (preload_val),
    .q_o      (reg_q)
  );

  pal_cell_drive u_drive (
    .mode_i    (mode),
    .comb_i    (cell_val),
    .q_i       (reg_q),
    .oe_n_i    (shared_oe_n),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe)
  );

  pal_cell_fb #(.IS_EDGE(IS_EDGE)) u_fb (
    .glob0_i    (cfg_glob0),
    .glob1_i    (cfg_glob1),
    .loc_mode_i (cfg_loc_mode),
    .q_i        (reg_q),
    .pad_i      (pad_in),
    .adj_i      (adj_pin),
    .fb_o       (fb_o)
  );

  p_comb_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_glob1 == cfg_loc_mode) |-> (pad_out == ((|sop_terms) ^ cfg_loc_inv)));

  p_reg_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_glob1 && !cfg_loc_mode) |-> (pad_oe == !shared_oe_n));

  p_io_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_glob1 && cfg_loc_mode) |-> pad_oe);

  p_comb_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_glob1 && !cfg_loc_mode) |-> pad_oe);

  p_dedicated_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_glob1 && cfg_loc_mode) |-> (!pad_oe && !pad_out));

  p_fb_adjacent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(IS_EDGE ? cfg_glob0 : cfg_glob1) |-> (fb_o == adj_pin));

  p_fb_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((IS_EDGE ? cfg_glob0 : cfg_glob1) && cfg_loc_mode) |-> (fb_o == pad_in));
endmodule

// File: tb/test_pal_out_cell.sv
module test_pal_out_cell;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic g0 = 1'b0, g1 = 1'b0, lm = 1'b0, li = 1'b0, oe_n = 1'b0;
  logic [NT-1:0] terms = '0;
  logic pl_en = 1'b0, pl_val = 1'b0, pad_in = 1'b0, adj = 1'b0;
  logic out_m, oe_m, fb_m, out_e, oe_e, fb_e;
  logic q_exp;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pal_out_cell #(.N_TERMS(NT), .NUM_CELLS(8), .CELL_INDEX(3)) i_pal_out_cell (
    .clk(clk), .rst_n(rst_n), .cfg_glob0(g0), .cfg_glob1(g1), .cfg_loc_mode(lm),
    .cfg_loc_inv(li), .shared_oe_n(oe_n), .sop_terms(terms), .preload_en(pl_en),
    .preload_val(pl_val), .pad_in(pad_in), .adj_pin(adj),
    .pad_out(out_m), .pad_oe(oe_m), .fb_o(fb_m));

  pal_out_cell #(.N_TERMS(NT), .NUM_CELLS(8), .CELL_INDEX(0)) i_pal_out_cell_edge (
    .clk(clk), .rst_n(rst_n), .cfg_glob0(g0), .cfg_glob1(g1), .cfg_loc_mode(lm),
    .cfg_loc_inv(li), .shared_oe_n(oe_n), .sop_terms(terms), .preload_en(pl_en),
    .preload_val(pl_val), .pad_in(pad_in), .adj_pin(adj),
    .pad_out(out_e), .pad_oe(oe_e), .fb_o(fb_e));

  // Register model from R2, R8, R9
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_exp <= 1'b0;
    else if (pl_en) q_exp <= pl_val;
    else            q_exp <= (terms != '0) ^ li;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (cfg g0=%b g1=%b lm=%b li=%b)",
               tag, act, exp, g0, g1, lm, li);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic logic fb_expect(input logic gsel);
    if (!gsel)   return adj;
    else if (lm) return pad_in;
    else         return q_exp;
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic val;
    // R8: reset state, registered mode, edge feedback from register
    g0 = 1'b1; g1 = 1'b1; lm = 1'b0; li = 1'b1; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_m, 1'b0, "R8 pad_out in reset");
    chk(fb_m, 1'b0, "R8 feedback in reset");
    chk(fb_e, 1'b0, "R8 edge feedback in reset");
    chk(oe_m, 1'b1, "R3 enable in reset");
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < (1 << 13); v++) begin
      @(negedge clk);
      {g0, g1, lm, li} = v[3:0];
      terms  = v[7:4];
      oe_n   = v[8];
      pad_in = v[9];
      adj    = v[10];
      pl_en  = v[11];
      pl_val = v[12];
      #1;
      val = (terms != '0) ^ li;
      unique case ({g1, lm})
        2'b10: begin
          chk(oe_m, ~oe_n, "R3 registered enable");
          chk(out_m, q_exp, "R2/R9 registered pad_out");
        end
        2'b11: begin
          chk(oe_m, 1'b1, "R4 I/O enable");
          chk(out_m, val, "R1 I/O pad_out");
        end
        2'b00: begin
          chk(oe_m, 1'b1, "R5 comb enable");
          chk(out_m, val, "R1 comb pad_out");
        end
        default: begin
          chk(oe_m, 1'b0, "R6 dedicated enable");
          chk(out_m, 1'b0, "R6 dedicated pad_out");
        end
      endcase
      chk(oe_e, oe_m, "R3/R4/R5/R6 edge enable");
      chk(fb_m, fb_expect(g1), g1 ? (lm ? "R4 fb pad" : "R2 fb reg") : "R5/R6 fb adjacent");
      chk(fb_e, fb_expect(g0), "R7 edge feedback");
    end

    // R9 then R8: preload a 1 against all-zero terms, then reset mid-run
    @(negedge clk);
    g0 = 1'b1; g1 = 1'b1; lm = 1'b0; li = 1'b0; terms = '0; pl_en = 1'b1; pl_val = 1'b1;
    @(negedge clk);
    pl_en = 1'b0;
    #1;
    chk(out_m, 1'b1, "R9 preload over zero terms");
    chk(fb_e, 1'b1, "R9 edge reg feedback after preload");
    rst_n = 1'b0;
    #1;
    chk(out_m, 1'b0, "R8 async clear");
    chk(fb_e, 1'b0, "R8 edge async clear");
    summary();
    $finish;
  end
endmodule